// File: doc/BRIEF.md
# LCD Blink and Bank Controller

This block decides, frame by frame, what the segment drivers of a low-multiplex LCD driver should show. It turns a slow timebase tick into a blink phase at one of three rates. From that phase, the selected blink style and the drive mode, it produces a blanking flag and the index of the display-RAM bank whose bits feed the segment outputs. It also produces a mask that names the RAM bit positions the chosen bank occupies.

A command decoder upstream writes the blink-rate code, the blink style, the bank choice and the drive mode. A frame sequencer supplies the frame strobe. The tick arrives once per half period of the fastest blink rate. A new blink-rate code is adopted only at a frame strobe, so a rate change never tears a frame. Changing to a different rate restarts the blink phase from its visible half.

Top module: `lcd_blink_bank_ctrl`

## Requirements
- R1: After synchronous reset the blink rate is off and the phase is in its visible half, so `blank_o` is 0 and `bank_o` equals `bank_sel_i`.
- R2: With rate code 2'b00 (off), `blank_o` stays 0 and `bank_o` equals `bank_sel_i`, whatever ticks or blink style arrive.
- R3: With rate code 2'b01 the blink phase flips on every tick.
- R4: With rate code 2'b10 the blink phase flips on every second tick.
- R5: With rate code 2'b11 the blink phase flips on every fourth tick.
- R6: With `alt_mode_i` = 0 (normal blinking) and a nonzero rate, `blank_o` is 1 in the hidden half of the phase and 0 in the visible half, and `bank_o` equals `bank_sel_i` throughout.
- R7: With `alt_mode_i` = 1, a nonzero rate and drive mode 2'b00 (static) or 2'b01 (1:2 multiplex), `blank_o` stays 0, and `bank_o` is the inverse of `bank_sel_i` in the second half of the phase.
- R8: With `alt_mode_i` = 1 in drive mode 2'b10 or 2'b11, the block behaves as in normal blinking (R6).
- R9: `ram_bits_o` (bit i = RAM bit i) is 4'b0001 for bank 0 and 4'b0100 for bank 1 in static mode, 4'b0011 and 4'b1100 in 1:2 mode, and 4'b1111 in the other modes.
- R10: `blink_code_i` is adopted only in a cycle with `frame_i` = 1. Adopting a different code restarts the divider and returns the phase to its visible half. Adopting the same code leaves the phase running.
- R11: When a frame strobe adopts a different code in the same cycle as a tick, the restart wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per half period of the fastest blink rate |
| frame_i | input | 1 | One-cycle frame-boundary strobe; the rate code is adopted here |
| blink_code_i | input | 2 | Blink rate: 00 off, 01 fast, 10 medium, 11 slow |
| alt_mode_i | input | 1 | 0 normal blinking, 1 bank alternation |
| drive_mode_i | input | 2 | 00 static, 01 1:2, 10 1:3, 11 1:4 multiplex |
| bank_sel_i | input | 1 | Bank shown when no alternation is in effect |
| blank_o | output | 1 | Segment outputs are to be blanked |
| bank_o | output | 1 | Bank index feeding the segment drivers |
| ram_bits_o | output | 4 | RAM bit positions used by the displayed bank |

## Verification
The rate code and the blink phase sit in registers. An adopted code or a tick therefore shows on the outputs in the cycle after the clock edge that saw it. Bank choice, blink style and drive mode pass straight through logic and take effect in the same cycle. The bench drives every input on the falling edge and holds a pulse for one full cycle. It samples one falling edge after the pulse, so the single register stage has updated and no input is changing. Rate behaviour is checked by counting ticks from a known restart, and each outcome is computed from the tick count and the rate.

// File: rtl/lbb_pkg.sv
package lbb_pkg;

    typedef enum logic [1:0] {
        BLINK_OFF  = 2'b00,
        BLINK_FAST = 2'b01,
        BLINK_MED  = 2'b10,
        BLINK_SLOW = 2'b11
    } blink_code_e;

    typedef enum logic [1:0] {
        DRV_STATIC = 2'b00,
        DRV_MUX2   = 2'b01,
        DRV_MUX3   = 2'b10,
        DRV_MUX4   = 2'b11
    } drive_mode_e;

    localparam int RAM_BITS = 4;

    typedef struct packed {
        logic                blank;
        logic                bank;
        logic [RAM_BITS-1:0] bits;
    } seg_view_t;

    // ticks between two phase flips for a rate code (1 when off, unused)
    function automatic int ticks_per_flip(blink_code_e c);
        case (c)
            BLINK_FAST: return 1;
            BLINK_MED:  return 2;
            BLINK_SLOW: return 4;
            default:    return 1;
        endcase
    endfunction

    function automatic logic alt_capable(drive_mode_e m);
        return (m == DRV_STATIC) || (m == DRV_MUX2);
    endfunction

    function automatic logic [RAM_BITS-1:0] bank_bits(drive_mode_e m, logic bank);
        case (m)
            DRV_STATIC: return bank ? 4'b0100 : 4'b0001;
            DRV_MUX2:   return bank ? 4'b1100 : 4'b0011;
            default:    return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/lbb_rate_gen.sv
module lbb_rate_gen
    import lbb_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        frame_i,
    input  logic [1:0]  code_i,
    output blink_code_e code_o,
    output logic        phase_o
);

    localparam logic [DIV_W-1:0] CNT_ZERO = '0;

    blink_code_e      code_q;
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic [DIV_W-1:0] cnt_last;
    logic             restart;

    assign cnt_last = DIV_W'(ticks_per_flip(code_q) - 1);
    assign restart  = frame_i && (code_i != code_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= BLINK_OFF;
            cnt_q   <= CNT_ZERO;
            phase_q <= 1'b0;
        end else begin
            if (frame_i) begin
                code_q <= blink_code_e'(code_i);
            end
            if (restart || code_q == BLINK_OFF) begin
                cnt_q   <= CNT_ZERO;
                phase_q <= 1'b0;
            end else if (tick_i) begin
                if (cnt_q == cnt_last) begin
                    cnt_q   <= CNT_ZERO;
                    phase_q <= ~phase_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign code_o  = code_q;
    assign phase_o = phase_q;

    // R10: the rate code changes only through a frame strobe
    assert_code_frame_only_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> $stable(code_q));

    // R10: a frame strobe adopts the presented code
    assert_code_adopt_R10: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (code_q == $past(code_i)));

    // R2: rate off holds the phase in its visible half
    assert_off_holds_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (code_q == BLINK_OFF) |=> !phase_q);

    // R3: fast rate flips on each tick unless a restart intervenes
    assert_fast_flip_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !frame_i && code_q == BLINK_FAST) |=> (phase_q != $past(phase_q)));

    // R4 R5: no tick and no frame leaves the phase alone
    assert_phase_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !frame_i) |=> $stable(phase_q));

    // R11: a restarting frame always lands in the visible half
    assert_restart_wins_R11: assert property (@(posedge clk) disable iff (rst)
        restart |=> !phase_q);

endmodule

// File: rtl/lbb_bank_map.sv
module lbb_bank_map
    import lbb_pkg::*;
(
    input  blink_code_e code_i,
    input  logic        phase_i,
    input  logic        alt_mode_i,
    input  logic [1:0]  drive_mode_i,
    input  logic        bank_sel_i,
    output seg_view_t   view_o
);

    drive_mode_e mode;
    logic        blinking;
    logic        alt_eff;
    logic        hidden_half;
    logic        bank;

    assign mode        = drive_mode_e'(drive_mode_i);
    assign blinking    = (code_i != BLINK_OFF);
    assign alt_eff     = alt_mode_i && alt_capable(mode);
    assign hidden_half = blinking && phase_i;
    assign bank        = bank_sel_i ^ (hidden_half && alt_eff);

    always_comb begin
        view_o.blank = hidden_half && !alt_eff;
        view_o.bank  = bank;
        view_o.bits  = bank_bits(mode, bank);
    end

endmodule

// File: rtl/lcd_blink_bank_ctrl.sv
module lcd_blink_bank_ctrl
    import lbb_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       frame_i,
    input  logic [1:0] blink_code_i,
    input  logic       alt_mode_i,
    input  logic [1:0] drive_mode_i,
    input  logic       bank_sel_i,
    output logic       blank_o,
    output logic       bank_o,
    output logic [3:0] ram_bits_o
);

    blink_code_e code;
    logic        phase;
    seg_view_t   view;

    lbb_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .frame_i (frame_i),
        .code_i  (blink_code_i),
        .code_o  (code),
        .phase_o (phase)
    );

    lbb_bank_map u_map (
        .code_i       (code),
        .phase_i      (phase),
        .alt_mode_i   (alt_mode_i),
        .drive_mode_i (drive_mode_i),
        .bank_sel_i   (bank_sel_i),
        .view_o       (view)
    );

    assign blank_o    = view.blank;
    assign bank_o     = view.bank;
    assign ram_bits_o = view.bits;

    // R2: blanking needs an active blink rate
    assert_blank_needs_rate_R2: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> (code != BLINK_OFF));

    // R7: alternation in static or 1:2 never blanks
    assert_alt_no_blank_R7: assert property (@(posedge clk) disable iff (rst)
        (alt_mode_i && !drive_mode_i[1]) |-> !blank_o);

    // R6: normal blinking never swaps the bank
    assert_normal_bank_R6: assert property (@(posedge clk) disable iff (rst)
        !alt_mode_i |-> (bank_o == bank_sel_i));

    // R9: static drive uses exactly one RAM bit, 1:2 exactly two
    assert_static_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (drive_mode_i == 2'b00) |-> ($countones(ram_bits_o) == 1));
    assert_mux2_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (drive_mode_i == 2'b01) |-> ($countones(ram_bits_o) == 2));

endmodule

// File: tb/lcd_blink_bank_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_blink_bank_ctrl_bench;

    localparam real CLK_NS = 4.0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       frame_i = 1'b0;
    logic [1:0] blink_code_i = 2'b00;
    logic       alt_mode_i = 1'b0;
    logic [1:0] drive_mode_i = 2'b00;
    logic       bank_sel_i = 1'b0;
    logic       blank_o;
    logic       bank_o;
    logic [3:0] ram_bits_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_NS/2) clk = ~clk;

    lcd_blink_bank_ctrl u_lcd_blink_bank_ctrl (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .frame_i      (frame_i),
        .blink_code_i (blink_code_i),
        .alt_mode_i   (alt_mode_i),
        .drive_mode_i (drive_mode_i),
        .bank_sel_i   (bank_sel_i),
        .blank_o      (blank_o),
        .bank_o       (bank_o),
        .ram_bits_o   (ram_bits_o)
    );

    // vector: {code[2], alt, mode[2], bank_sel, ticks[3], exp_blank, exp_bank, exp_bits[4]}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {2'b01, 1'b0, 2'b00, 1'b0, 3'd1, 1'b1, 1'b0, 4'b0001}, // R6 R3
        {2'b01, 1'b0, 2'b00, 1'b0, 3'd2, 1'b0, 1'b0, 4'b0001}, // R3
        {2'b01, 1'b1, 2'b00, 1'b0, 3'd1, 1'b0, 1'b1, 4'b0100}, // R7 R9
        {2'b01, 1'b1, 2'b01, 1'b1, 3'd1, 1'b0, 1'b0, 4'b0011}, // R7 R9
        {2'b01, 1'b1, 2'b01, 1'b1, 3'd0, 1'b0, 1'b1, 4'b1100}, // R7 R9
        {2'b01, 1'b1, 2'b10, 1'b0, 3'd1, 1'b1, 1'b0, 4'b1111}, // R8 R9
        {2'b01, 1'b1, 2'b11, 1'b1, 3'd1, 1'b1, 1'b1, 4'b1111}, // R8 R9
        {2'b10, 1'b0, 2'b00, 1'b0, 3'd1, 1'b0, 1'b0, 4'b0001}, // R4
        {2'b10, 1'b0, 2'b00, 1'b1, 3'd2, 1'b1, 1'b1, 4'b0100}, // R4 R6
        {2'b11, 1'b1, 2'b00, 1'b0, 3'd3, 1'b0, 1'b0, 4'b0001}, // R5
        {2'b11, 1'b1, 2'b00, 1'b0, 3'd4, 1'b0, 1'b1, 4'b0100}, // R5 R7
        {2'b00, 1'b0, 2'b00, 1'b0, 3'd4, 1'b0, 1'b0, 4'b0001}, // R2
        {2'b00, 1'b1, 2'b01, 1'b1, 3'd3, 1'b0, 1'b1, 4'b1100}, // R2
        {2'b11, 1'b0, 2'b01, 1'b1, 3'd6, 1'b1, 1'b1, 4'b1100}  // R5 R6
    };

    task automatic chk(input string tag, input logic eb, input logic ek, input logic [3:0] em);
        checks++;
        if ({blank_o, bank_o, ram_bits_o} !== {eb, ek, em}) begin
            errors++;
            $display("FAIL %s: actual blank=%b bank=%b bits=%b expected blank=%b bank=%b bits=%b",
                     tag, blank_o, bank_o, ram_bits_o, eb, ek, em);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tick_i = 1'b0; frame_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pulse_frame(input logic [1:0] c);
        @(negedge clk);
        blink_code_i = c; frame_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0;
    endtask

    task automatic frame_with_tick(input logic [1:0] c);
        @(negedge clk);
        blink_code_i = c; frame_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        bank_sel_i = 1'b1;
        do_reset();
        @(negedge clk);
        chk("R1 reset", 1'b0, 1'b1, 4'b0100);

        // table walk: R2..R9
        for (int i = 0; i < NV; i++) begin
            logic [14:0] v;
            v = VEC[i];
            do_reset();
            alt_mode_i   = v[12];
            drive_mode_i = v[11:10];
            bank_sel_i   = v[9];
            pulse_frame(v[14:13]);
            ticks(int'(v[8:6]));
            chk($sformatf("R6/R7/R8/R9 table vector %0d", i), v[5], v[4], v[3:0]);
        end

        // R3: fast rate flips on each tick
        do_reset();
        alt_mode_i = 1'b0; drive_mode_i = 2'b00; bank_sel_i = 1'b0;
        pulse_frame(2'b01);
        for (int k = 0; k < 4; k++) begin
            ticks(1);
            chk("R3 fast flip", (k % 2 == 0), 1'b0, 4'b0001);
        end

        // R10: code without a frame is ignored
        do_reset();
        pulse_frame(2'b01);
        ticks(1);
        chk("R10 running fast", 1'b1, 1'b0, 4'b0001);
        blink_code_i = 2'b10;
        ticks(1);
        chk("R10 code ignored without frame", 1'b0, 1'b0, 4'b0001);
        pulse_frame(2'b10);
        ticks(1);
        chk("R10 medium first tick", 1'b0, 1'b0, 4'b0001);
        ticks(1);
        chk("R10 medium second tick", 1'b1, 1'b0, 4'b0001);
        pulse_frame(2'b10);
        chk("R10 same code keeps phase", 1'b1, 1'b0, 4'b0001);
        pulse_frame(2'b01);
        chk("R10 new code restarts", 1'b0, 1'b0, 4'b0001);

        // R11: restart beats a simultaneous tick
        ticks(1);
        chk("R11 setup hidden half", 1'b1, 1'b0, 4'b0001);
        frame_with_tick(2'b10);
        chk("R11 restart wins", 1'b0, 1'b0, 4'b0001);
        ticks(1);
        chk("R11 tick dropped count", 1'b0, 1'b0, 4'b0001);
        ticks(1);
        chk("R11 medium flip", 1'b1, 1'b0, 4'b0001);

        // R2: switching off mid-blink clears the blank
        pulse_frame(2'b00);
        chk("R2 off clears blank", 1'b0, 1'b0, 4'b0001);
        alt_mode_i = 1'b1;
        ticks(2);
        chk("R2 off ignores ticks", 1'b0, 1'b0, 4'b0001);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule